// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register store of a 32-bit processor core. Software sees sixteen registers at any moment. Which physical storage stands behind each of those sixteen depends on the processor mode presented on the `mode` input. The block holds thirty general storage words plus the program counter. Registers 0 to 7 are common to every mode. Registers 8 to 12 have one extra private set that only the fast-interrupt mode uses. Registers 13 (stack pointer) and 14 (link) have a private copy for each exception mode, and the user and system modes share one copy between them.

Two combinational read ports and one clocked write port are each addressed by a 4-bit logical index. A second, dedicated write port loads the link register of any chosen mode. Exception entry uses it to store a return address into the target mode's link register in the same cycle that it switches `mode`. Index 15 is the program counter. Reading it returns the stored address plus a fixed pipeline offset. Writing it clears the two low bits.

Top module: `bankedRegFile`

## Requirements
- R1: After reset every general register reads 0 and the program counter holds 0, so a read of index 15 returns 8.
- R2: Indices 0 to 7 select the same storage in every mode. A value written in one mode is read back in any other mode.
- R3: Indices 8 to 12 select one shared set in all modes except fast interrupt (mode 5'b10001), which has a private set of five.
- R4: Indices 13 and 14 each have six copies: one shared by user (5'b10000) and system (5'b11111), and one private copy each for fast interrupt (5'b10001), interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011).
- R5: For each of the seven mode codes listed in R4, `modeErr` is 0.
- R6: Any other mode value selects the user/system bank and drives `modeErr` to 1 in the same cycle.
- R7: A read of index 15 returns the program counter plus 8, modulo 2^32.
- R8: A write to index 15 stores `wrData` with bits [1:0] forced to 0.
- R9: Reads are combinational and show the register contents before the clock edge. A register being written returns its old value in that cycle and the new value from the next cycle on.
- R10: When `lnkWrEn` is 1, the link port writes index 14 of the bank chosen by `lnkWrMode`, whatever the current `mode` is. An unknown `lnkWrMode` selects the user/system bank.
- R11: When the main port and the link port write the same storage word in one cycle, the link port's value is kept.
- R12: The two read ports are independent. Each returns its own index's value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current processor mode code |
| rdIdxA | input | 4 | Logical index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdIdxB | input | 4 | Logical index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Main write enable |
| wrIdx | input | 4 | Logical index for main write (current mode's bank) |
| wrData | input | 32 | Main write data |
| lnkWrEn | input | 1 | Link-register write enable |
| lnkWrMode | input | 5 | Mode whose link register is written |
| lnkWrData | input | 32 | Link write data |
| modeErr | output | 1 | 1 when `mode` is not a recognised code |

## Verification
The read ports and `modeErr` are combinational. Their values are due in the same cycle as the index and mode that select them. A write becomes visible only on a read in the cycle after the clock edge that takes it. Each table row therefore drives its inputs just after a falling edge and checks the outputs a quarter period later, before the rising edge that commits its own write. Each expected read therefore reflects every earlier row's write and never the current row's. The checker states the same timing: write data appears one cycle later, and reads stay stable when no write occurs and the selection is unchanged.

// File: rtl/bankRegPkg.sv
package bankRegPkg;

  localparam int PHYS_W = 5;   // width of a physical storage index
  localparam int GPR_N  = 30;  // general storage words, program counter excluded
  localparam int BANK_W = 3;   // width of a bank number

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpuMode_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic [PHYS_W-1:0] physA;
    logic [PHYS_W-1:0] physB;
    logic              pcSelA;
    logic              pcSelB;
    logic              gprWe;
    logic [PHYS_W-1:0] gprWIdx;
    logic              pcWe;
    logic              linkWe;
    logic [PHYS_W-1:0] linkWIdx;
  } rfStrobes_t;

  // Bank number: 0 user/system, 1 fast irq, 2 irq, 3 svc, 4 abort, 5 undef
  function automatic logic [BANK_W-1:0] bankOf(input logic [4:0] m);
    logic [BANK_W-1:0] b;
    case (m)
      MODE_FIQ: b = 3'd1;
      MODE_IRQ: b = 3'd2;
      MODE_SVC: b = 3'd3;
      MODE_ABT: b = 3'd4;
      MODE_UND: b = 3'd5;
      default:  b = 3'd0;
    endcase
    return b;
  endfunction

  function automatic logic modeKnown(input logic [4:0] m);
    logic k;
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: k = 1'b1;
      default:                      k = 1'b0;
    endcase
    return k;
  endfunction

  // Storage layout: 0..7 common, 8..12 shared high, 13..17 fast-irq high,
  // 18+2*bank stack pointer, 19+2*bank link register
  function automatic logic [PHYS_W-1:0] physIndex(input logic [3:0] idx,
                                                  input logic [BANK_W-1:0] bank);
    logic [PHYS_W-1:0] p;
    if (idx < 4'd8) begin
      p = PHYS_W'(idx);
    end else if (idx < 4'd13) begin
      p = (bank == 3'd1) ? PHYS_W'(idx) + PHYS_W'(5) : PHYS_W'(idx);
    end else if (idx == 4'd13) begin
      p = PHYS_W'(18) + PHYS_W'({bank, 1'b0});
    end else begin
      p = PHYS_W'(19) + PHYS_W'({bank, 1'b0});
    end
    return p;
  endfunction

endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankRegPkg::*;
(
  input  logic [4:0]  mode,
  input  logic [3:0]  rdIdxA,
  input  logic [3:0]  rdIdxB,
  input  logic        wrEn,
  input  logic [3:0]  wrIdx,
  input  logic        lnkWrEn,
  input  logic [4:0]  lnkWrMode,
  output rfStrobes_t  strobes,
  output logic        modeErr
);

  localparam logic [3:0] PC_IDX = 4'd15;

  logic [BANK_W-1:0] curBank;
  logic [BANK_W-1:0] lnkBank;

  always_comb begin
    curBank = bankOf(mode);
    lnkBank = bankOf(lnkWrMode);
    modeErr = ~modeKnown(mode);
  end

  always_comb begin
    strobes          = '0;
    strobes.physA    = physIndex(rdIdxA, curBank);
    strobes.physB    = physIndex(rdIdxB, curBank);
    strobes.pcSelA   = (rdIdxA == PC_IDX);
    strobes.pcSelB   = (rdIdxB == PC_IDX);
    strobes.gprWe    = wrEn && (wrIdx != PC_IDX);
    strobes.gprWIdx  = physIndex(wrIdx, curBank);
    strobes.pcWe     = wrEn && (wrIdx == PC_IDX);
    strobes.linkWe   = lnkWrEn;
    strobes.linkWIdx = physIndex(4'd14, lnkBank);
  end

endmodule

// File: rtl/bankData.sv
module bankData
  import bankRegPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] lnkWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam logic [DATA_W-1:0] PC_ADD   = DATA_W'(PC_OFFSET);
  localparam logic [DATA_W-1:0] ALIGN_MK = ~DATA_W'(3);

  logic [DATA_W-1:0] gpr [GPR_N];
  logic [DATA_W-1:0] pcQ;

  for (genvar i = 0; i < GPR_N; i++) begin : g_word
    logic mainHit;
    logic linkHit;
    always_comb begin
      mainHit = strobes.gprWe  && (strobes.gprWIdx  == PHYS_W'(i));
      linkHit = strobes.linkWe && (strobes.linkWIdx == PHYS_W'(i));
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gpr[i] <= '0;
      end else if (linkHit) begin
        gpr[i] <= lnkWrData;   // link port has priority
      end else if (mainHit) begin
        gpr[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (strobes.pcWe) begin
      pcQ <= wrData & ALIGN_MK;
    end
  end

  always_comb begin
    rdDataA = strobes.pcSelA ? pcQ + PC_ADD : gpr[strobes.physA];
    rdDataB = strobes.pcSelB ? pcQ + PC_ADD : gpr[strobes.physB];
  end

endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRegPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        mode,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lnkWrEn,
  input  logic [4:0]        lnkWrMode,
  input  logic [DATA_W-1:0] lnkWrData,
  output logic              modeErr
);

  rfStrobes_t strobes;

  bankCtrl i_ctrl (
    .mode      (mode),
    .rdIdxA    (rdIdxA),
    .rdIdxB    (rdIdxB),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .lnkWrEn   (lnkWrEn),
    .lnkWrMode (lnkWrMode),
    .strobes   (strobes),
    .modeErr   (modeErr)
  );

  bankData #(
    .DATA_W    (DATA_W),
    .PC_OFFSET (PC_OFFSET)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .lnkWrData (lnkWrData),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB)
  );

endmodule

// File: rtl/bankedRegFileChk.sv
module bankedRegFileChk #(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        mode,
  input logic [3:0]        rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              lnkWrEn,
  input logic [4:0]        lnkWrMode,
  input logic [DATA_W-1:0] lnkWrData,
  input logic              modeErr
);

  localparam logic [DATA_W-1:0] PC_ADD = DATA_W'(PC_OFFSET);
  localparam logic [DATA_W-1:0] LOW_MK = DATA_W'(3);

  // R7: program counter reads stay word aligned
  a_r7_pc_read_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == 4'd15) |-> ((rdDataA & LOW_MK) == '0));

  // R8: a write to index 15 reads back aligned plus offset
  a_r8_pc_write_align: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 4'd15) |=>
      (rdIdxA != 4'd15 || rdDataA == (($past(wrData) & ~LOW_MK) + PC_ADD)));

  // R9: written data appears in the following cycle
  a_r9_write_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != 4'd15 && wrIdx != 4'd14 && !lnkWrEn) |=>
      (rdIdxB != $past(wrIdx) || mode != $past(mode) || rdDataB == $past(wrData)));

  // R9: no write and unchanged selection keeps read data stable
  a_r9_read_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !lnkWrEn) |=>
      (mode != $past(mode) || rdIdxA != $past(rdIdxA) || rdDataA == $past(rdDataA)));

  // R10: link port lands in the target mode's link register
  a_r10_link_lands: assert property (@(posedge clk) disable iff (!rstN)
    lnkWrEn |=>
      (mode != $past(lnkWrMode) || rdIdxA != 4'd14 || rdDataA == $past(lnkWrData)));

  // R6: only codes with the top bit set can be recognised
  a_r6_err_when_low: assert property (@(posedge clk) disable iff (!rstN)
    (mode[4] == 1'b0) |-> modeErr);

endmodule

bind bankedRegFile bankedRegFileChk #(
  .DATA_W    (DATA_W),
  .PC_OFFSET (PC_OFFSET)
) i_bankedRegFileChk (.*);

// File: tb/test_bankedRegFile.sv
module test_bankedRegFile;

  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] MU = 5'b10000;
  localparam logic [4:0] MF = 5'b10001;
  localparam logic [4:0] MI = 5'b10010;
  localparam logic [4:0] MS = 5'b10011;
  localparam logic [4:0] MA = 5'b10111;
  localparam logic [4:0] MN = 5'b11011;
  localparam logic [4:0] MY = 5'b11111;

  typedef struct packed {
    logic [4:0]  md;
    logic        we;
    logic [3:0]  wi;
    logic [31:0] wd;
    logic        le;
    logic [4:0]  lm;
    logic [31:0] ld;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
    logic        ee;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // md  we  wi     wd            le  lm     ld            ra     rb     ea            eb            ee   tag
    '{MU, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd15, 4'd3,  32'h8,        32'h0,        1'b0,8'd7},  // R7 after reset
    '{MU, 1'b1,4'd3, 32'h11111111, 1'b0,MU,   32'h0,        4'd3,  4'd3,  32'h0,        32'h0,        1'b0,8'd9},  // R9 old value
    '{MF, 1'b1,4'd9, 32'hF9,       1'b0,MU,   32'h0,        4'd3,  4'd9,  32'h11111111, 32'h0,        1'b0,8'd2},  // R2
    '{MU, 1'b1,4'd9, 32'h09,       1'b0,MU,   32'h0,        4'd9,  4'd3,  32'h0,        32'h11111111, 1'b0,8'd3},  // R3
    '{MF, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd9,  4'd9,  32'hF9,       32'hF9,       1'b0,8'd3},  // R3
    '{MS, 1'b1,4'd13,32'h5D,       1'b0,MU,   32'h0,        4'd9,  4'd13, 32'h09,       32'h0,        1'b0,8'd3},  // R3
    '{MY, 1'b1,4'd13,32'h1D,       1'b0,MU,   32'h0,        4'd13, 4'd9,  32'h0,        32'h09,       1'b0,8'd4},  // R4
    '{MU, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd13, 4'd14, 32'h1D,       32'h0,        1'b0,8'd4},  // R4
    '{MS, 1'b1,4'd15,32'h1003,     1'b0,MU,   32'h0,        4'd13, 4'd3,  32'h5D,       32'h11111111, 1'b0,8'd12}, // R12
    '{MI, 1'b0,4'd0, 32'h0,        1'b1,MA,   32'hAB,       4'd15, 4'd13, 32'h1008,     32'h0,        1'b0,8'd8},  // R8
    '{MA, 1'b1,4'd14,32'h77,       1'b1,MA,   32'hCC,       4'd14, 4'd13, 32'hAB,       32'h0,        1'b0,8'd10}, // R10
    '{MA, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd14, 4'd14, 32'hCC,       32'hCC,       1'b0,8'd11}, // R11
    '{5'b10100,1'b1,4'd14,32'hE1,  1'b0,MU,   32'h0,        4'd13, 4'd14, 32'h1D,       32'h0,        1'b1,8'd6},  // R6
    '{MU, 1'b0,4'd0, 32'h0,        1'b1,5'd0, 32'hE2,       4'd14, 4'd15, 32'hE1,       32'h1008,     1'b0,8'd6},  // R6
    '{MY, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd14, 4'd13, 32'hE2,       32'h1D,       1'b0,8'd10}, // R10
    '{MN, 1'b1,4'd8, 32'h88,       1'b0,MU,   32'h0,        4'd14, 4'd8,  32'h0,        32'h0,        1'b0,8'd4},  // R4
    '{MF, 1'b1,4'd7, 32'h70,       1'b0,MU,   32'h0,        4'd8,  4'd7,  32'h0,        32'h0,        1'b0,8'd3},  // R3
    '{MI, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd8,  4'd7,  32'h88,       32'h70,       1'b0,8'd2},  // R2
    '{MS, 1'b1,4'd15,32'hFFFFFFFF, 1'b0,MU,   32'h0,        4'd13, 4'd14, 32'h5D,       32'h0,        1'b0,8'd5},  // R5
    '{MS, 1'b0,4'd0, 32'h0,        1'b0,MU,   32'h0,        4'd15, 4'd13, 32'h4,        32'h5D,       1'b0,8'd8}   // R8 wrap
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  mode;
  logic [3:0]  rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData, lnkWrData;
  logic        wrEn, lnkWrEn, modeErr;
  logic [4:0]  lnkWrMode;

  int checks = 0;
  int errors = 0;

  bankedRegFile i_bankedRegFile (
    .clk(clk), .rstN(rstN), .mode(mode),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .lnkWrEn(lnkWrEn), .lnkWrMode(lnkWrMode), .lnkWrData(lnkWrData),
    .modeErr(modeErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; wrIdx = '0; wrData = '0;
    lnkWrEn = 1'b0; lnkWrMode = MU; lnkWrData = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; mode = MU; rdIdxA = '0; rdIdxB = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdIdxA = 4'd15; rdIdxB = 4'd0;
    #(CLK_PERIOD/4);
    check("R1 pc", rdDataA, 32'h8);
    check("R1 r0", rdDataB, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].md; wrEn = VEC[i].we; wrIdx = VEC[i].wi; wrData = VEC[i].wd;
      lnkWrEn = VEC[i].le; lnkWrMode = VEC[i].lm; lnkWrData = VEC[i].ld;
      rdIdxA = VEC[i].ra; rdIdxB = VEC[i].rb;
      #(CLK_PERIOD/4);
      check($sformatf("R%0d row %0d portA", VEC[i].tag, i), rdDataA, VEC[i].ea);
      check($sformatf("R%0d row %0d portB", VEC[i].tag, i), rdDataB, VEC[i].eb);
      check($sformatf("R%0d row %0d err", VEC[i].tag, i), 32'(modeErr), 32'(VEC[i].ee));
    end
    @(negedge clk);
    idle();

    // R5: each recognised code has no error; R4: stack pointer copies
    begin
      logic [4:0] codes [7];
      codes = '{MU, MF, MI, MS, MA, MN, MY};
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        mode = codes[k]; wrEn = 1'b1; wrIdx = 4'd13; wrData = 32'h100 + 32'(k);
        #(CLK_PERIOD/4);
        check($sformatf("R5 code %b", codes[k]), 32'(modeErr), 32'h0);
      end
      @(negedge clk);
      idle();
      // user and system share: last system write (0x106) visible in user
      mode = MU; rdIdxA = 4'd13;
      #(CLK_PERIOD/4);
      check("R4 usr/sys shared sp", rdDataA, 32'h106);
      mode = MF;
      #(CLK_PERIOD/4);
      check("R4 fiq sp", rdDataA, 32'h101);
      mode = MN;
      #(CLK_PERIOD/4);
      check("R4 und sp", rdDataA, 32'h105);
    end

    // R1: reset mid-run clears contents
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; mode = MU; rdIdxA = 4'd3; rdIdxB = 4'd15;
    #(CLK_PERIOD/4);
    check("R1 r3 cleared", rdDataA, 32'h0);
    check("R1 pc cleared", rdDataB, 32'h8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule